// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a 20-bit physical memory address for a processor that uses real-mode segmentation. A request names an access mode. There are fetch, stack-top and string-destination requests, which have fixed register pairs. There are also six data-operand modes, which build a 16-bit effective offset from a base pointer, an index pointer and a displacement. The block picks the default segment register from the pointers that the mode uses, and it applies an optional segment override to data operands. It then forms `segment * 16 + offset`.

The caller presents the current register values, the mode code, pointer selects, the displacement and the override on one cycle with `req_i` high. One clock later the block presents the physical address and the index of the segment register it used, with `valid_o` high. When no legal request is accepted, `valid_o` drops and the address and segment outputs keep their last values.

Top module: `seg_addr_gen`

## Requirements
- R1: After a legal request, the physical address equals (segment value << 4) + 16-bit effective offset, taken modulo 2^20. It appears on `paddr_o` with `valid_o` high on the clock edge that follows the request.
- R2: Mode 0 (instruction fetch) uses the code segment with `ip_i` as the offset. The segment index codes on `seg_o` are 0 = extra, 1 = code, 2 = stack, 3 = data.
- R3: Mode 1 (stack top) uses the stack segment with `sp_i`.
- R4: Mode 2 (string destination) uses the extra segment with `di_i`.
- R5: Mode 3 (direct) uses the full 16-bit `disp_i` as the offset, with the data segment as default.
- R6: Mode 4 uses the base pointer alone and mode 5 uses the index pointer alone. `base_sel_i` 0 picks `bx_i` and 1 picks `bp_i`; `idx_sel_i` 0 picks `si_i` and 1 picks `di_i`. Any mode built on `bp_i` defaults to the stack segment, and every other data mode defaults to the data segment.
- R7: Mode 6 adds base plus displacement, mode 7 adds index plus displacement, and mode 8 adds base plus index plus displacement. The offset sum wraps modulo 2^16 before the segment is added.
- R8: When `disp_wide_i` is 0, only `disp_i[7:0]` is used, sign-extended to 16 bits, in modes 6 to 8. When it is 1, all 16 bits are used.
- R9: For modes 3 to 8, `ovr_en_i` = 1 replaces the default segment with the one coded on `ovr_seg_i`. For modes 0 to 2 the override has no effect.
- R10: When `req_i` is low, or the mode is one of the reserved codes 9 to 15, `valid_o` is low on the next cycle and `paddr_o` and `seg_o` hold their previous values.
- R11: While `rst_n` is low, `valid_o`, `paddr_o` and `seg_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe |
| mode_i | input | 4 | Access mode code (0 to 8 legal) |
| base_sel_i | input | 1 | Base pointer select: 0 = bx_i, 1 = bp_i |
| idx_sel_i | input | 1 | Index pointer select: 0 = si_i, 1 = di_i |
| disp_wide_i | input | 1 | 1 = 16-bit displacement, 0 = 8-bit signed |
| disp_i | input | 16 | Displacement or direct offset |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_seg_i | input | 2 | Override segment index |
| cs_i | input | 16 | Code segment value |
| ds_i | input | 16 | Data segment value |
| ss_i | input | 16 | Stack segment value |
| es_i | input | 16 | Extra segment value |
| ip_i | input | 16 | Instruction pointer |
| sp_i | input | 16 | Stack pointer |
| bx_i | input | 16 | Base pointer for the data segment |
| bp_i | input | 16 | Base pointer for the stack segment |
| si_i | input | 16 | Source index pointer |
| di_i | input | 16 | Destination index pointer |
| valid_o | output | 1 | Result valid |
| paddr_o | output | 20 | Physical address |
| seg_o | output | 2 | Segment index used |

## Verification
Every result is due on the first rising edge after the cycle in which the request is presented. There is exactly one register between the inputs and the outputs. The bench changes inputs on the falling edge, lets one rising edge pass, and compares all three outputs on the next falling edge against a model that works from the requirements. On non-request and reserved-mode cycles, the same sampling point confirms that the valid flag is low and that the address and segment still equal the last accepted result.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_e;

    typedef enum logic [3:0] {
        MD_FETCH     = 4'd0,
        MD_STACK     = 4'd1,
        MD_STRDST    = 4'd2,
        MD_DIRECT    = 4'd3,
        MD_REG_BASE  = 4'd4,
        MD_REG_IDX   = 4'd5,
        MD_BASE_DISP = 4'd6,
        MD_IDX_DISP  = 4'd7,
        MD_BIDX_DISP = 4'd8
    } mode_e;

    localparam int unsigned NUM_SEGS   = 4;
    localparam logic [3:0]  MODE_LAST  = 4'd8;
    localparam logic [3:0]  DATA_FIRST = 4'd3;
endpackage

// File: rtl/sag_offset_unit.sv
module sag_offset_unit
    import seg_addr_pkg::*;
#(
    parameter int unsigned OFF_W         = 16,
    parameter int unsigned DISP_NARROW_W = 8
) (
    input  logic [3:0]       mode_i,
    input  logic             base_sel_i,
    input  logic             idx_sel_i,
    input  logic             disp_wide_i,
    input  logic [OFF_W-1:0] disp_i,
    input  logic [OFF_W-1:0] ip_i,
    input  logic [OFF_W-1:0] sp_i,
    input  logic [OFF_W-1:0] bx_i,
    input  logic [OFF_W-1:0] bp_i,
    input  logic [OFF_W-1:0] si_i,
    input  logic [OFF_W-1:0] di_i,
    output logic [OFF_W-1:0] offset_o,
    output seg_e             dflt_seg_o,
    output logic             legal_o,
    output logic             data_mode_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [OFF_W-1:0] narrow_ext;
    logic [OFF_W-1:0] disp_ext;
    logic [OFF_W-1:0] base_val;
    logic [OFF_W-1:0] idx_val;
    seg_e             base_seg;

    // Short displacement: replicate its sign bit up to the offset width.
    if (DISP_NARROW_W < OFF_W) begin : g_sext
        assign narrow_ext = {{(OFF_W-DISP_NARROW_W){disp_i[DISP_NARROW_W-1]}},
                             disp_i[DISP_NARROW_W-1:0]};
    end else begin : g_nosext
        assign narrow_ext = disp_i;
    end

    assign disp_ext = disp_wide_i ? disp_i : narrow_ext;
    assign base_val = base_sel_i ? bp_i : bx_i;
    assign idx_val  = idx_sel_i  ? di_i : si_i;
    assign base_seg = base_sel_i ? SEG_SS : SEG_DS;

    always_comb begin
        offset_o    = '0;
        dflt_seg_o  = SEG_DS;
        legal_o     = 1'b1;
        data_mode_o = 1'b1;
        case (mode_e'(mode_i))
            MD_FETCH: begin
                offset_o    = ip_i;
                dflt_seg_o  = SEG_CS;
                data_mode_o = 1'b0;
            end
            MD_STACK: begin
                offset_o    = sp_i;
                dflt_seg_o  = SEG_SS;
                data_mode_o = 1'b0;
            end
            MD_STRDST: begin
                offset_o    = di_i;
                dflt_seg_o  = SEG_ES;
                data_mode_o = 1'b0;
            end
            MD_DIRECT: begin
                offset_o = disp_i;
            end
            MD_REG_BASE: begin
                offset_o   = base_val;
                dflt_seg_o = base_seg;
            end
            MD_REG_IDX: begin
                offset_o = idx_val;
            end
            MD_BASE_DISP: begin
                offset_o   = base_val + disp_ext;
                dflt_seg_o = base_seg;
            end
            MD_IDX_DISP: begin
                offset_o = idx_val + disp_ext;
            end
            MD_BIDX_DISP: begin
                offset_o   = base_val + idx_val + disp_ext;
                dflt_seg_o = base_seg;
            end
            default: begin
                legal_o     = 1'b0;
                data_mode_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sag_seg_unit.sv
module sag_seg_unit
    import seg_addr_pkg::*;
#(
    parameter int unsigned SEG_W = 16
) (
    input  logic [NUM_SEGS-1:0][SEG_W-1:0] seg_bank_i,
    input  seg_e                           dflt_seg_i,
    input  logic                           data_mode_i,
    input  logic                           ovr_en_i,
    input  logic [1:0]                     ovr_seg_i,
    output seg_e                           seg_sel_o,
    output logic [SEG_W-1:0]               seg_val_o
);
    timeunit 1ns;
    timeprecision 1ps;

    // The override only reaches data operands; fetch, stack and string destination keep their segment.
    assign seg_sel_o = (data_mode_i && ovr_en_i) ? seg_e'(ovr_seg_i) : dflt_seg_i;
    assign seg_val_o = seg_bank_i[seg_sel_o];
endmodule

// File: rtl/sag_phys_adder.sv
module sag_phys_adder #(
    parameter int unsigned SEG_W   = 16,
    parameter int unsigned OFF_W   = 16,
    parameter int unsigned SHIFT_W = 4,
    localparam int unsigned ADDR_W = SEG_W + SHIFT_W
) (
    input  logic [SEG_W-1:0]  seg_val_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] paddr_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [ADDR_W-1:0] seg_shift;
    logic [ADDR_W-1:0] off_ext;

    assign seg_shift = {seg_val_i, {SHIFT_W{1'b0}}};

    if (ADDR_W > OFF_W) begin : g_zext
        assign off_ext = {{(ADDR_W-OFF_W){1'b0}}, offset_i};
    end else begin : g_trunc
        assign off_ext = offset_i[ADDR_W-1:0];
    end

    // The carry out of the top bit is dropped, so the address wraps at the address width.
    assign paddr_o = seg_shift + off_ext;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int unsigned SEG_W         = 16,
    parameter int unsigned OFF_W         = 16,
    parameter int unsigned SHIFT_W       = 4,
    parameter int unsigned DISP_NARROW_W = 8,
    localparam int unsigned ADDR_W       = SEG_W + SHIFT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [3:0]        mode_i,
    input  logic              base_sel_i,
    input  logic              idx_sel_i,
    input  logic              disp_wide_i,
    input  logic [OFF_W-1:0]  disp_i,
    input  logic              ovr_en_i,
    input  logic [1:0]        ovr_seg_i,
    input  logic [SEG_W-1:0]  cs_i,
    input  logic [SEG_W-1:0]  ds_i,
    input  logic [SEG_W-1:0]  ss_i,
    input  logic [SEG_W-1:0]  es_i,
    input  logic [OFF_W-1:0]  ip_i,
    input  logic [OFF_W-1:0]  sp_i,
    input  logic [OFF_W-1:0]  bx_i,
    input  logic [OFF_W-1:0]  bp_i,
    input  logic [OFF_W-1:0]  si_i,
    input  logic [OFF_W-1:0]  di_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] paddr_o,
    output logic [1:0]        seg_o
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        seg_e              seg;
    } out_t;

    out_t out_d, out_q;

    logic [OFF_W-1:0]                offset;
    seg_e                            dflt_seg;
    logic                            legal;
    logic                            data_mode;
    seg_e                            seg_sel;
    logic [SEG_W-1:0]                seg_val;
    logic [ADDR_W-1:0]               paddr_c;
    logic [NUM_SEGS-1:0][SEG_W-1:0]  seg_bank;

    assign seg_bank[SEG_ES] = es_i;
    assign seg_bank[SEG_CS] = cs_i;
    assign seg_bank[SEG_SS] = ss_i;
    assign seg_bank[SEG_DS] = ds_i;

    sag_offset_unit #(
        .OFF_W         (OFF_W),
        .DISP_NARROW_W (DISP_NARROW_W)
    ) u_offset (
        .mode_i      (mode_i),
        .base_sel_i  (base_sel_i),
        .idx_sel_i   (idx_sel_i),
        .disp_wide_i (disp_wide_i),
        .disp_i      (disp_i),
        .ip_i        (ip_i),
        .sp_i        (sp_i),
        .bx_i        (bx_i),
        .bp_i        (bp_i),
        .si_i        (si_i),
        .di_i        (di_i),
        .offset_o    (offset),
        .dflt_seg_o  (dflt_seg),
        .legal_o     (legal),
        .data_mode_o (data_mode)
    );

    sag_seg_unit #(
        .SEG_W (SEG_W)
    ) u_seg (
        .seg_bank_i  (seg_bank),
        .dflt_seg_i  (dflt_seg),
        .data_mode_i (data_mode),
        .ovr_en_i    (ovr_en_i),
        .ovr_seg_i   (ovr_seg_i),
        .seg_sel_o   (seg_sel),
        .seg_val_o   (seg_val)
    );

    sag_phys_adder #(
        .SEG_W   (SEG_W),
        .OFF_W   (OFF_W),
        .SHIFT_W (SHIFT_W)
    ) u_add (
        .seg_val_i (seg_val),
        .offset_i  (offset),
        .paddr_o   (paddr_c)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = 1'b0;
        if (req_i && legal) begin
            out_d.vld  = 1'b1;
            out_d.addr = paddr_c;
            out_d.seg  = seg_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{vld: 1'b0, addr: '0, seg: SEG_ES};
        end else begin
            out_q <= out_d;
        end
    end

    assign valid_o = out_q.vld;
    assign paddr_o = out_q.addr;
    assign seg_o   = out_q.seg;

    // R10: valid follows a legal request by exactly one cycle
    p_valid_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (valid_o == $past(req_i && (mode_i <= MODE_LAST))));

    // R10: results hold when nothing is accepted
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !valid_o) |-> ($stable(paddr_o) && $stable(seg_o)));

    // R2: fetch always reports the code segment, whatever the override says
    p_fetch_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_i && (mode_i == MD_FETCH)) |-> (seg_o == SEG_CS));

    // R1: the low nibble of a fetch address comes straight from the instruction pointer
    p_fetch_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_i && (mode_i == MD_FETCH))
            |-> (paddr_o[SHIFT_W-1:0] == $past(ip_i[SHIFT_W-1:0])));

    // R3: stack requests use the stack segment
    p_stack_ss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_i && (mode_i == MD_STACK)) |-> (seg_o == SEG_SS));

    // R4: string destination uses the extra segment
    p_strdst_es_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_i && (mode_i == MD_STRDST)) |-> (seg_o == SEG_ES));

    // R6: modes built on the stack base pointer default to the stack segment
    p_bp_ss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_i && !ovr_en_i && base_sel_i &&
              ((mode_i == MD_REG_BASE) || (mode_i == MD_BASE_DISP) || (mode_i == MD_BIDX_DISP)))
            |-> (seg_o == SEG_SS));

    // R9: an override on a data operand selects the named segment
    p_override_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_i && ovr_en_i && (mode_i >= DATA_FIRST) && (mode_i <= MODE_LAST))
            |-> (seg_o == $past(ovr_seg_i)));
endmodule

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_i;
    logic [3:0]  mode_i;
    logic        base_sel_i, idx_sel_i, disp_wide_i, ovr_en_i;
    logic [15:0] disp_i;
    logic [1:0]  ovr_seg_i;
    logic [15:0] cs_i, ds_i, ss_i, es_i, ip_i, sp_i, bx_i, bp_i, si_i, di_i;
    logic        valid_o;
    logic [19:0] paddr_o;
    logic [1:0]  seg_o;

    int errors = 0;
    int checks = 0;
    logic [19:0] last_addr = '0;
    logic [1:0]  last_seg  = '0;

    always #5 clk = ~clk;

    seg_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
        .base_sel_i(base_sel_i), .idx_sel_i(idx_sel_i), .disp_wide_i(disp_wide_i),
        .disp_i(disp_i), .ovr_en_i(ovr_en_i), .ovr_seg_i(ovr_seg_i),
        .cs_i(cs_i), .ds_i(ds_i), .ss_i(ss_i), .es_i(es_i),
        .ip_i(ip_i), .sp_i(sp_i), .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i),
        .valid_o(valid_o), .paddr_o(paddr_o), .seg_o(seg_o)
    );

    // Reference model from the requirements: returns {valid, seg, addr}
    function automatic logic [22:0] model();
        logic [15:0] off, dx, bv, iv;
        logic [1:0]  sg;
        logic        data;
        logic [19:0] pa;
        logic [15:0] sv;
        dx   = disp_wide_i ? disp_i : {{8{disp_i[7]}}, disp_i[7:0]};   // R8
        bv   = base_sel_i ? bp_i : bx_i;
        iv   = idx_sel_i ? di_i : si_i;
        data = 1'b1;
        sg   = 2'd3;
        off  = 16'h0;
        if (!req_i || mode_i > 4'd8) return {1'b0, last_seg, last_addr};  // R10
        case (mode_i)
            4'd0: begin off = ip_i; sg = 2'd1; data = 1'b0; end        // R2
            4'd1: begin off = sp_i; sg = 2'd2; data = 1'b0; end        // R3
            4'd2: begin off = di_i; sg = 2'd0; data = 1'b0; end        // R4
            4'd3: off = disp_i;                                        // R5
            4'd4: begin off = bv; sg = base_sel_i ? 2'd2 : 2'd3; end   // R6
            4'd5: off = iv;
            4'd6: begin off = bv + dx; sg = base_sel_i ? 2'd2 : 2'd3; end  // R7
            4'd7: off = iv + dx;
            default: begin off = bv + iv + dx; sg = base_sel_i ? 2'd2 : 2'd3; end
        endcase
        if (data && ovr_en_i) sg = ovr_seg_i;                          // R9
        case (sg)
            2'd0: sv = es_i;
            2'd1: sv = cs_i;
            2'd2: sv = ss_i;
            default: sv = ds_i;
        endcase
        pa = {sv, 4'h0} + {4'h0, off};                                 // R1
        return {1'b1, sg, pa};
    endfunction

    function automatic string tag_of(input logic [3:0] m, input logic rq);
        if (!rq || m > 4'd8) return "R10";
        case (m)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4, 4'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Inputs are already set before the falling edge; one rising edge registers them, compare at the next falling edge.
    task automatic step_check(input string tag);
        logic [22:0] exp;
        exp = model();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if ({valid_o, seg_o, paddr_o} !== exp) begin
            errors++;
            $display("FAIL %s R1: actual v=%0b seg=%0d addr=%05h expected v=%0b seg=%0d addr=%05h",
                     tag, valid_o, seg_o, paddr_o, exp[22], exp[21:20], exp[19:0]);
        end
        if (exp[22]) begin
            last_addr = exp[19:0];
            last_seg  = exp[21:20];
        end
    endtask

    task automatic clear_inputs();
        req_i = 0; mode_i = 0; base_sel_i = 0; idx_sel_i = 0; disp_wide_i = 1;
        disp_i = 0; ovr_en_i = 0; ovr_seg_i = 0;
        cs_i = 0; ds_i = 0; ss_i = 0; es_i = 0; ip_i = 0; sp_i = 0;
        bx_i = 0; bp_i = 0; si_i = 0; di_i = 0;
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        clear_inputs();
        rst_n = 0;
        req_i = 1;
        mode_i = 0;
        cs_i = 16'h1234;
        repeat (3) @(negedge clk);
        // R11: reset state even with a request present
        checks++;
        if (valid_o !== 1'b0 || paddr_o !== 20'h0 || seg_o !== 2'd0) begin
            errors++;
            $display("FAIL R11: actual v=%0b addr=%05h seg=%0d expected v=0 addr=00000 seg=0",
                     valid_o, paddr_o, seg_o);
        end
        req_i = 0;
        rst_n = 1;
        @(negedge clk);

        // R2/R1: fetch 24F6:634A -> 2B2AA, override ignored (R9)
        clear_inputs(); req_i = 1; mode_i = 0; cs_i = 16'h24F6; ip_i = 16'h634A;
        ovr_en_i = 1; ovr_seg_i = 2'd3; ds_i = 16'h7777;
        step_check("R2 R9");
        // R3: stack SS=3500 SP=FFFE -> 44FFE
        clear_inputs(); req_i = 1; mode_i = 1; ss_i = 16'h3500; sp_i = 16'hFFFE;
        ovr_en_i = 1; ovr_seg_i = 2'd0;
        step_check("R3 R9");
        // R4: string destination
        clear_inputs(); req_i = 1; mode_i = 2; es_i = 16'h1000; di_i = 16'h0ABC;
        step_check("R4");
        // R1: 20-bit wrap FFFF:0010 -> 00000
        clear_inputs(); req_i = 1; mode_i = 3; ds_i = 16'hFFFF; disp_i = 16'h0010;
        step_check("R1 R5");
        // R10: idle cycle holds
        clear_inputs(); ds_i = 16'h4444;
        step_check("R10");
        // R10: reserved mode
        req_i = 1; mode_i = 4'd12;
        step_check("R10");
        // R7: offset wraps at 16 bits: BX=FFFF SI=0002 disp 0 -> offset 0001
        clear_inputs(); req_i = 1; mode_i = 8; ds_i = 16'h0200; bx_i = 16'hFFFF; si_i = 16'h0002;
        step_check("R7");
        // R8: short displacement 0x80 sign-extends to FF80
        clear_inputs(); req_i = 1; mode_i = 6; disp_wide_i = 0; disp_i = 16'h1280;
        bx_i = 16'h0100; ds_i = 16'h0300;
        step_check("R8");
        // R6: BP alone defaults to stack segment
        clear_inputs(); req_i = 1; mode_i = 4; base_sel_i = 1; bp_i = 16'h0042;
        ss_i = 16'h5000; ds_i = 16'h6000;
        step_check("R6");
        // R9: override on BX operand selects extra segment
        clear_inputs(); req_i = 1; mode_i = 4; bx_i = 16'h0010; ds_i = 16'h1111;
        es_i = 16'h2222; ovr_en_i = 1; ovr_seg_i = 2'd0;
        step_check("R9");

        // Constrained random mix
        for (int i = 0; i < 2000; i++) begin
            req_i       = ($urandom % 8) != 0;
            mode_i      = (($urandom % 10) == 0) ? 4'($urandom % 16) : 4'($urandom % 9);
            base_sel_i  = 1'($urandom);
            idx_sel_i   = 1'($urandom);
            disp_wide_i = 1'($urandom);
            disp_i      = 16'($urandom);
            ovr_en_i    = ($urandom % 3) == 0;
            ovr_seg_i   = 2'($urandom);
            cs_i = 16'($urandom); ds_i = 16'($urandom); ss_i = 16'($urandom); es_i = 16'($urandom);
            ip_i = 16'($urandom); sp_i = 16'($urandom); bx_i = 16'($urandom); bp_i = 16'($urandom);
            si_i = 16'($urandom); di_i = 16'($urandom);
            step_check(tag_of(mode_i, req_i));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule